// File: doc/BRIEF.md
# Transparent Serial Frame Link

This block is a paired serial transmitter and receiver for bit-transparent frames. Frame boundaries are not marked by flags or sync patterns in the data. Instead, the sender drives a frame-active side line for exactly the bits of a frame, and that line is wired to the carrier input of the far receiver. Both directions run from one system clock. Each direction has its own bit strobe, and the two directions are independent of each other. The transmitter can begin a frame on any strobe; there is no clear-to-send handshake.

The transmitter pulls bytes from a valid/ready stream. Each byte carries a last-in-frame marker and an append-CRC flag. Bits go out least significant first, and the frame may close with a CRC. The CRC is 16 or 32 bits wide and starts from a programmable seed. The receiver collects bits while the carrier is high. It hands out whole bytes, and it ends the frame when the carrier drops. At that point it reports a status: the byte count, the carrier-lost bit, a flag for a frame that did not end on a byte boundary, and a CRC check against a programmable residue.

Top module: `sfl_link`

## Requirements
- R1: `frame_out` rises on a `tx_bit_en` strobe where `s_valid` is high with the frame idle. On that same strobe, `ser_out` carries bit 0 of the accepted byte. `s_ready` is high only on strobes where a new byte is needed.
- R2: `frame_out` stays high for every data bit and every appended CRC bit. It drops on the first strobe after the final bit of a byte whose `s_last` was set. A byte without `s_last` is followed directly by the next byte.
- R3: Data bits leave least significant bit first, one bit per strobe. While no frame is active, `ser_out` is 1 and `frame_out` is 0.
- R4: A CRC follows the payload only when `s_crc` was set on the byte marked `s_last`. The CRC register is sent most significant bit first.
- R5: The CRC register is loaded from `crc_seed`. For each bit b it updates as: fb = top bit XOR b, shift left by one, then XOR the polynomial when fb is 1. `crc_wide`=1 selects 32 bits with polynomial 0x04C11DB7. `crc_wide`=0 selects 16 bits with polynomial 0x1021 and uses only bits 15:0 of `crc_seed` and `crc_residue`.
- R6: If a byte is needed in mid-frame and `s_valid` is low, the transmitter ends the frame at once. It pulses `tx_underrun` for one cycle, drops `frame_out` and sends no CRC.
- R7: The first strobe with `carrier_in` high samples the first frame bit. Bits are packed least significant first. Each byte is delivered as a one-cycle `m_valid` pulse when the following byte completes, or at frame end.
- R8: A `rx_bit_en` strobe that sees `carrier_in` low during a frame ends the frame. For one cycle `rx_end` is high with `rx_cd_lost`=1 and `rx_count` equal to the number of whole bytes. The final byte, if any, appears in that same cycle with `m_valid` and `m_last`.
- R9: Bits left over after the last whole byte are dropped, and `rx_misaligned` is set in the end status.
- R10: The receiver CRC runs over every sampled bit, starting from the seed. `rx_crc_err` is 1 at frame end only when `rx_crc_en` is 1 and the register differs from `crc_residue` within the active width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_bit_en | input | 1 | Transmit bit strobe |
| rx_bit_en | input | 1 | Receive bit strobe |
| crc_wide | input | 1 | 1: 32-bit CRC, 0: 16-bit CRC |
| crc_seed | input | 32 | CRC preset value |
| crc_residue | input | 32 | Expected final receive CRC value |
| rx_crc_en | input | 1 | Enable the receive CRC check |
| s_data | input | 8 | Transmit byte |
| s_valid | input | 1 | Transmit byte valid |
| s_last | input | 1 | Byte is the last of its frame |
| s_crc | input | 1 | Append CRC (taken from the last byte) |
| s_ready | output | 1 | Transmit byte accepted this cycle |
| ser_out | output | 1 | Serial data out |
| frame_out | output | 1 | Frame-active line out |
| tx_underrun | output | 1 | One-cycle underrun pulse |
| ser_in | input | 1 | Serial data in |
| carrier_in | input | 1 | Carrier (frame-active) in |
| m_data | output | 8 | Received byte |
| m_valid | output | 1 | Received byte strobe |
| m_last | output | 1 | Received byte is the final one |
| rx_end | output | 1 | Frame end status strobe |
| rx_count | output | 16 | Whole bytes in the frame |
| rx_crc_err | output | 1 | CRC mismatch |
| rx_cd_lost | output | 1 | Frame closed by carrier loss |
| rx_misaligned | output | 1 | Frame had leftover bits |

## Verification
In most tests the transmitter drives the receiver in a loop. Several frame shapes are used: plain multi-byte payloads, a 16-bit CRC with junk in the unused upper seed bits, and a 32-bit CRC. The captured serial bits must match an independent model bit for bit, and the delivered bytes must match too. Extra cases separate CRC flags given only on a non-last byte, a wrong residue with the check switched on and off, and a stream that runs dry in mid-frame. The receiver is also driven directly with a frame that stops four bits past a byte boundary, which exposes bit order, dropping of the leftover bits and the alignment flag.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    localparam int unsigned CRC_W    = 32;
    localparam int unsigned NARROW_W = 16;
    localparam logic [CRC_W-1:0] POLY_WIDE   = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] POLY_NARROW = 32'h0000_1021;
    localparam logic [CRC_W-1:0] NARROW_MASK = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_DATA = 2'd1,
        TX_CRC  = 2'd2
    } tx_state_e;

    function automatic logic [CRC_W-1:0] width_mask(input logic wide);
        return wide ? {CRC_W{1'b1}} : NARROW_MASK;
    endfunction
endpackage

// File: rtl/sfl_crc_bit.sv
module sfl_crc_bit
    import sfl_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    input  logic             wide,
    output logic [CRC_W-1:0] crc_out
);
    logic             fb;
    logic [CRC_W-1:0] shifted;

    always_comb begin
        fb      = (wide ? crc_in[CRC_W-1] : crc_in[NARROW_W-1]) ^ bit_in;
        shifted = {crc_in[CRC_W-2:0], 1'b0};
        crc_out = shifted ^ (fb ? (wide ? POLY_WIDE : POLY_NARROW) : '0);
        crc_out = crc_out & width_mask(wide);
    end
endmodule

// File: rtl/sfl_tx.sv
module sfl_tx
    import sfl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              crc_wide,
    input  logic [CRC_W-1:0]  crc_seed,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_crc,
    output logic              s_ready,
    output logic              ser_out,
    output logic              frame_out,
    output logic              underrun
);
    localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);
    localparam int unsigned CCNT_W = $clog2(CRC_W + 1);
    localparam logic [BCNT_W-1:0] BYTE_DONE = BCNT_W'(BYTE_W);

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] sr;
        logic [BCNT_W-1:0] cnt;
        logic              last;
        logic              addcrc;
        logic              wide;
        logic [CRC_W-1:0]  crc;
        logic [CCNT_W-1:0] ccnt;
        logic              ser;
        logic              frame;
        logic              urun;
    } tx_regs_t;

    tx_regs_t q, d;

    logic             need_byte;
    logic             take;
    logic             step_bit;
    logic             step_wide;
    logic [CRC_W-1:0] step_in;
    logic [CRC_W-1:0] step_out;
    logic             crc_top;
    logic [CCNT_W-1:0] crc_len;

    always_comb begin
        need_byte = bit_en && ((q.st == TX_IDLE) ||
                    ((q.st == TX_DATA) && (q.cnt == BYTE_DONE) && !q.last));
        take      = need_byte && s_valid;
        step_bit  = take ? s_data[0] : q.sr[0];
        step_wide = (q.st == TX_IDLE) ? crc_wide : q.wide;
        step_in   = (q.st == TX_IDLE) ? (crc_seed & width_mask(crc_wide)) : q.crc;
        crc_top   = q.wide ? q.crc[CRC_W-1] : q.crc[NARROW_W-1];
        crc_len   = q.wide ? CCNT_W'(CRC_W) : CCNT_W'(NARROW_W);
    end

    sfl_crc_bit u_crc (
        .crc_in  (step_in),
        .bit_in  (step_bit),
        .wide    (step_wide),
        .crc_out (step_out)
    );

    always_comb begin
        d      = q;
        d.urun = 1'b0;
        if (bit_en) begin
            unique case (q.st)
                TX_IDLE: begin
                    if (take) begin
                        d.st     = TX_DATA;
                        d.sr     = s_data >> 1;
                        d.cnt    = BCNT_W'(1);
                        d.last   = s_last;
                        d.addcrc = s_crc;
                        d.wide   = crc_wide;
                        d.crc    = step_out;
                        d.ser    = s_data[0];
                        d.frame  = 1'b1;
                    end
                end
                TX_DATA: begin
                    if (q.cnt != BYTE_DONE) begin
                        d.ser = q.sr[0];
                        d.sr  = q.sr >> 1;
                        d.crc = step_out;
                        d.cnt = q.cnt + BCNT_W'(1);
                    end else if (!q.last) begin
                        if (take) begin
                            d.sr     = s_data >> 1;
                            d.cnt    = BCNT_W'(1);
                            d.last   = s_last;
                            d.addcrc = s_crc;
                            d.crc    = step_out;
                            d.ser    = s_data[0];
                        end else begin
                            d.st    = TX_IDLE;
                            d.urun  = 1'b1;
                            d.frame = 1'b0;
                            d.ser   = 1'b1;
                        end
                    end else if (q.addcrc) begin
                        d.st   = TX_CRC;
                        d.ser  = crc_top;
                        d.crc  = q.crc << 1;
                        d.ccnt = CCNT_W'(1);
                    end else begin
                        d.st    = TX_IDLE;
                        d.frame = 1'b0;
                        d.ser   = 1'b1;
                    end
                end
                TX_CRC: begin
                    if (q.ccnt == crc_len) begin
                        d.st    = TX_IDLE;
                        d.frame = 1'b0;
                        d.ser   = 1'b1;
                    end else begin
                        d.ser  = crc_top;
                        d.crc  = q.crc << 1;
                        d.ccnt = q.ccnt + CCNT_W'(1);
                    end
                end
                default: d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= TX_IDLE;
            q.sr     <= '0;
            q.cnt    <= '0;
            q.last   <= 1'b0;
            q.addcrc <= 1'b0;
            q.wide   <= 1'b0;
            q.crc    <= '0;
            q.ccnt   <= '0;
            q.ser    <= 1'b1;
            q.frame  <= 1'b0;
            q.urun   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign s_ready   = need_byte;
    assign ser_out   = q.ser;
    assign frame_out = q.frame;
    assign underrun  = q.urun;

    // R1
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_out) |-> $past(bit_en) && $past(s_valid));

    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_out && !bit_en) |=> frame_out);

    // R6
    no_frame_on_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !frame_out && ser_out);
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx
    import sfl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              crc_wide,
    input  logic [CRC_W-1:0]  crc_seed,
    input  logic [CRC_W-1:0]  crc_residue,
    input  logic              crc_chk_en,
    input  logic              ser_in,
    input  logic              carrier_in,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    output logic              f_end,
    output logic [CNT_W-1:0]  f_count,
    output logic              f_crc_err,
    output logic              f_lost,
    output logic              f_misaligned
);
    localparam int unsigned BIDX_W = $clog2(BYTE_W);
    localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(BYTE_W - 1);

    typedef struct packed {
        logic              active;
        logic [BYTE_W-1:0] sr;
        logic [BIDX_W-1:0] cnt;
        logic [BYTE_W-1:0] held;
        logic              held_v;
        logic [CNT_W-1:0]  bytes;
        logic [CRC_W-1:0]  crc;
        logic              wide;
        logic [BYTE_W-1:0] o_data;
        logic              o_valid;
        logic              o_last;
        logic              o_end;
        logic [CNT_W-1:0]  o_count;
        logic              o_err;
        logic              o_lost;
        logic              o_mis;
    } rx_regs_t;

    rx_regs_t q, d;

    logic [CRC_W-1:0]  step_in;
    logic [CRC_W-1:0]  step_out;
    logic              step_wide;
    logic [BYTE_W-1:0] base_sr;
    logic [BIDX_W-1:0] base_cnt;
    logic              base_hv;
    logic [CNT_W-1:0]  base_bytes;
    logic [BYTE_W-1:0] new_sr;

    always_comb begin
        step_in    = q.active ? q.crc : (crc_seed & width_mask(crc_wide));
        step_wide  = q.active ? q.wide : crc_wide;
        base_sr    = q.active ? q.sr : '0;
        base_cnt   = q.active ? q.cnt : '0;
        base_hv    = q.active ? q.held_v : 1'b0;
        base_bytes = q.active ? q.bytes : '0;
        new_sr     = {ser_in, base_sr[BYTE_W-1:1]};
    end

    sfl_crc_bit u_crc (
        .crc_in  (step_in),
        .bit_in  (ser_in),
        .wide    (step_wide),
        .crc_out (step_out)
    );

    always_comb begin
        d         = q;
        d.o_valid = 1'b0;
        d.o_last  = 1'b0;
        d.o_end   = 1'b0;
        d.o_err   = 1'b0;
        d.o_lost  = 1'b0;
        d.o_mis   = 1'b0;
        if (bit_en) begin
            if (carrier_in) begin
                d.active = 1'b1;
                d.wide   = step_wide;
                d.crc    = step_out;
                d.sr     = new_sr;
                d.cnt    = base_cnt + BIDX_W'(1);
                d.held_v = base_hv;
                d.bytes  = base_bytes;
                if (base_cnt == LAST_BIT) begin
                    if (base_hv) begin
                        d.o_data  = q.held;
                        d.o_valid = 1'b1;
                    end
                    d.held   = new_sr;
                    d.held_v = 1'b1;
                    d.bytes  = base_bytes + CNT_W'(1);
                end
            end else if (q.active) begin
                d.active  = 1'b0;
                d.held_v  = 1'b0;
                d.o_end   = 1'b1;
                d.o_data  = q.held;
                d.o_valid = q.held_v;
                d.o_last  = q.held_v;
                d.o_count = q.bytes;
                d.o_lost  = 1'b1;
                d.o_mis   = (q.cnt != '0);
                d.o_err   = crc_chk_en &&
                            (((q.crc ^ crc_residue) & width_mask(q.wide)) != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign m_data       = q.o_data;
    assign m_valid      = q.o_valid;
    assign m_last       = q.o_last;
    assign f_end        = q.o_end;
    assign f_count      = q.o_count;
    assign f_crc_err    = q.o_err;
    assign f_lost       = q.o_lost;
    assign f_misaligned = q.o_mis;

    // R8
    last_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid && f_end);

    // R8
    end_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_end |-> $past(bit_en) && !$past(carrier_in));

    // R7
    byte_in_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !f_end) |-> $past(bit_en) && $past(carrier_in));

    // R10
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_crc_err || f_misaligned) |-> f_end && f_lost);
endmodule

// File: rtl/sfl_link.sv
module sfl_link
    import sfl_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_bit_en,
    input  logic              rx_bit_en,
    input  logic              crc_wide,
    input  logic [31:0]       crc_seed,
    input  logic [31:0]       crc_residue,
    input  logic              rx_crc_en,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    input  logic              s_last,
    input  logic              s_crc,
    output logic              s_ready,
    output logic              ser_out,
    output logic              frame_out,
    output logic              tx_underrun,
    input  logic              ser_in,
    input  logic              carrier_in,
    output logic [BYTE_W-1:0] m_data,
    output logic              m_valid,
    output logic              m_last,
    output logic              rx_end,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_crc_err,
    output logic              rx_cd_lost,
    output logic              rx_misaligned
);
    sfl_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (tx_bit_en),
        .crc_wide  (crc_wide),
        .crc_seed  (crc_seed),
        .s_data    (s_data),
        .s_valid   (s_valid),
        .s_last    (s_last),
        .s_crc     (s_crc),
        .s_ready   (s_ready),
        .ser_out   (ser_out),
        .frame_out (frame_out),
        .underrun  (tx_underrun)
    );

    sfl_rx #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (rx_bit_en),
        .crc_wide     (crc_wide),
        .crc_seed     (crc_seed),
        .crc_residue  (crc_residue),
        .crc_chk_en   (rx_crc_en),
        .ser_in       (ser_in),
        .carrier_in   (carrier_in),
        .m_data       (m_data),
        .m_valid      (m_valid),
        .m_last       (m_last),
        .f_end        (rx_end),
        .f_count      (rx_count),
        .f_crc_err    (rx_crc_err),
        .f_lost       (rx_cd_lost),
        .f_misaligned (rx_misaligned)
    );
endmodule

// File: tb/test_sfl_link.sv
`timescale 1ns/1ps
module test_sfl_link;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        tick_prev = 1'b0;
    logic        crc_wide = 1'b0;
    logic [31:0] crc_seed = '0;
    logic [31:0] crc_residue = '0;
    logic        rx_crc_en = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_crc = 1'b0;
    logic        s_ready, ser_out, frame_out, tx_underrun;
    logic        drv_mode = 1'b0, drv_ser = 1'b1, drv_car = 1'b0;
    logic        ser_in, carrier_in;
    logic [7:0]  m_data;
    logic        m_valid, m_last, rx_end;
    logic [15:0] rx_count;
    logic        rx_crc_err, rx_cd_lost, rx_misaligned;

    int nchk = 0, nerr = 0, phase = 0;
    logic       tx_bits [0:511];
    int         tx_n;
    logic       exp_bits [0:511];
    int         exp_n;
    logic [7:0] rx_bytes [0:63];
    int         rx_n, last_cnt, urun_cnt;
    logic       end_seen, st_err, st_lost, st_mis, st_last;
    logic [15:0] st_count;
    logic [7:0] fbuf [0:15];

    assign ser_in     = drv_mode ? drv_ser : ser_out;
    assign carrier_in = drv_mode ? drv_car : frame_out;

    always #2.5 clk = ~clk;

    sfl_link i_sfl_link (
        .clk(clk), .rst_n(rst_n), .tx_bit_en(bit_en), .rx_bit_en(bit_en),
        .crc_wide(crc_wide), .crc_seed(crc_seed), .crc_residue(crc_residue),
        .rx_crc_en(rx_crc_en), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_crc(s_crc), .s_ready(s_ready), .ser_out(ser_out),
        .frame_out(frame_out), .tx_underrun(tx_underrun), .ser_in(ser_in),
        .carrier_in(carrier_in), .m_data(m_data), .m_valid(m_valid),
        .m_last(m_last), .rx_end(rx_end), .rx_count(rx_count),
        .rx_crc_err(rx_crc_err), .rx_cd_lost(rx_cd_lost),
        .rx_misaligned(rx_misaligned)
    );

    // strobe every fourth clock, changed just after the edge
    always @(posedge clk) begin
        tick_prev = bit_en;
        #1;
        phase = (phase + 1) % 4;
        bit_en = (phase == 0);
    end

    always @(negedge clk) begin
        if (tick_prev && frame_out && tx_n < 512) begin
            tx_bits[tx_n] = ser_out;
            tx_n++;
        end
        if (tx_underrun) urun_cnt++;
        if (m_valid && rx_n < 64) begin
            rx_bytes[rx_n] = m_data;
            rx_n++;
            if (m_last) last_cnt++;
        end
        if (rx_end) begin
            end_seen = 1'b1;
            st_count = rx_count;
            st_err   = rx_crc_err;
            st_lost  = rx_cd_lost;
            st_mis   = rx_misaligned;
            st_last  = m_last;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        tx_n = 0; rx_n = 0; last_cnt = 0; urun_cnt = 0;
        end_seen = 1'b0; exp_n = 0;
    endtask

    task automatic add_bit(input logic b);
        exp_bits[exp_n] = b;
        exp_n++;
    endtask

    // expected serial stream: data LSB first, then CRC MSB first
    task automatic build_exp(input int n, input bit addcrc, input bit wide,
                             input logic [31:0] seed);
        logic [31:0] c, poly, mask;
        int w;
        logic fb;
        w    = wide ? 32 : 16;
        poly = wide ? 32'h04C11DB7 : 32'h1021;
        mask = wide ? 32'hFFFFFFFF : 32'hFFFF;
        c    = seed & mask;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                add_bit(fbuf[i][k]);
                fb = c[w-1] ^ fbuf[i][k];
                c  = (c << 1) & mask;
                if (fb) c = c ^ poly;
            end
        end
        if (addcrc)
            for (int k = w - 1; k >= 0; k--) add_bit(c[k]);
    endtask

    task automatic push_frame(input int n, input bit crc_last, input bit crc_other);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_data  = fbuf[i];
            s_last  = (i == n - 1);
            s_crc   = (i == n - 1) ? crc_last : crc_other;
            s_valid = 1'b1;
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        s_crc   = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int t = 0;
        while (!end_seen && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "frame end seen", end_seen, 1);
        repeat (8) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        logic [7:0] eb;
        chk(req, "bits sent while frame active", tx_n, exp_n);
        for (int i = 0; i < exp_n && i < tx_n; i++)
            if (tx_bits[i] !== exp_bits[i]) begin
                chk(req, $sformatf("tx bit %0d", i), tx_bits[i], exp_bits[i]);
                break;
            end
        chk(req, "bytes delivered", rx_n, exp_n / 8);
        for (int i = 0; i < exp_n / 8 && i < rx_n; i++) begin
            for (int k = 0; k < 8; k++) eb[k] = exp_bits[8 * i + k];
            chk(req, $sformatf("rx byte %0d", i), rx_bytes[i], eb);
        end
        chk("R8", "status count", st_count, exp_n / 8);
        chk("R8", "carrier lost", st_lost, 1);
        chk("R8", "final byte marked", last_cnt, (exp_n >= 8) ? 1 : 0);
        chk("R2", "frame line low after frame", frame_out, 0);
    endtask

    task automatic t_reset();
        chk("R3", "idle serial level in reset", ser_out, 1);
        chk("R3", "frame line in reset", frame_out, 0);
        chk("R7", "no byte in reset", m_valid, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3", "idle serial level", ser_out, 1);
        chk("R1", "no ready while idle stream", s_ready & ~bit_en, 0);
        chk("R8", "no end while idle", rx_end, 0);
    endtask

    task automatic t_plain();
        clear_mon();
        crc_wide = 1'b0; rx_crc_en = 1'b0;
        fbuf[0] = 8'hA5; fbuf[1] = 8'h3C; fbuf[2] = 8'h81;
        build_exp(3, 0, 0, 0);
        push_frame(3, 0, 0);
        wait_end("R2");
        check_stream("R1/R3/R7 plain");
        chk("R10", "no crc error when check off", st_err, 0);
        chk("R9", "aligned frame", st_mis, 0);
    endtask

    task automatic t_crc16();
        clear_mon();
        crc_wide = 1'b0; rx_crc_en = 1'b1;
        crc_seed = 32'hABCD_FFFF; crc_residue = 32'h1234_0000;
        fbuf[0] = 8'h12; fbuf[1] = 8'hF0;
        build_exp(2, 1, 0, 32'h0000_FFFF);
        push_frame(2, 1, 0);
        wait_end("R4");
        check_stream("R4/R5 crc16");
        chk("R5", "residue match in narrow mode", st_err, 0);
    endtask

    task automatic t_crc32();
        clear_mon();
        crc_wide = 1'b1; rx_crc_en = 1'b1;
        crc_seed = 32'hFFFF_FFFF; crc_residue = 32'h0;
        fbuf[0] = 8'hDE; fbuf[1] = 8'hAD; fbuf[2] = 8'hBE; fbuf[3] = 8'hEF;
        build_exp(4, 1, 1, 32'hFFFF_FFFF);
        push_frame(4, 1, 0);
        wait_end("R4");
        check_stream("R4/R5 crc32");
        chk("R10", "crc32 residue match", st_err, 0);
    endtask

    task automatic t_crc_bad(input bit en);
        clear_mon();
        crc_wide = 1'b0; rx_crc_en = en;
        crc_seed = 32'h0000_1D0F; crc_residue = 32'h0000_0001;
        fbuf[0] = 8'h55;
        build_exp(1, 1, 0, 32'h1D0F);
        push_frame(1, 1, 0);
        wait_end("R10");
        chk("R10", en ? "mismatch flagged" : "mismatch ignored when off", st_err, en);
        chk("R10", "bytes incl crc", st_count, 3);
    endtask

    task automatic t_crc_nonlast();
        clear_mon();
        crc_wide = 1'b0; rx_crc_en = 1'b0;
        fbuf[0] = 8'h01; fbuf[1] = 8'h80;
        build_exp(2, 0, 0, 0);
        push_frame(2, 0, 1);
        wait_end("R4");
        check_stream("R4 flag only on non-last byte");
    endtask

    task automatic t_underrun();
        clear_mon();
        crc_wide = 1'b0; rx_crc_en = 1'b0;
        fbuf[0] = 8'h6B;
        build_exp(1, 0, 0, 0);
        @(negedge clk);
        s_data = 8'h6B; s_last = 1'b0; s_crc = 1'b1; s_valid = 1'b1;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_crc = 1'b0;
        wait_end("R6");
        chk("R6", "underrun pulses", urun_cnt, 1);
        check_stream("R6 no crc after underrun");
    endtask

    task automatic drive_bit(input logic car, input logic b);
        @(negedge clk);
        while (!tick_prev) @(negedge clk);
        drv_car = car;
        drv_ser = b;
    endtask

    task automatic t_misaligned();
        logic [7:0] v;
        logic [3:0] extra;
        clear_mon();
        rx_crc_en = 1'b0;
        drv_mode = 1'b1;
        v = 8'hC6; extra = 4'b1101;
        for (int k = 0; k < 8; k++) drive_bit(1'b1, v[k]);
        for (int k = 0; k < 4; k++) drive_bit(1'b1, extra[k]);
        drive_bit(1'b0, 1'b1);
        wait_end("R9");
        chk("R9", "whole bytes only", st_count, 1);
        chk("R9", "misaligned flag", st_mis, 1);
        chk("R7", "lsb-first byte", rx_bytes[0], 8'hC6);
        chk("R7", "one byte delivered", rx_n, 1);
        chk("R8", "final byte with end", st_last, 1);
        drv_mode = 1'b0;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (5) @(negedge clk);
        t_reset();
        t_plain();
        t_crc16();
        t_crc32();
        t_crc_bad(1'b1);
        t_crc_bad(1'b0);
        t_crc_nonlast();
        t_underrun();
        t_misaligned();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule